// File: doc/BRIEF.md
# Register Bus Cycle Master

This block drives one side of a simple synchronous register bus of the strobe/acknowledge kind. A client hands it one request at a time on a valid/ready command port: a single read, a single write, or a read-modify-write. The block turns each request into bus cycles on a registered address, write-data, write-flag and strobe set. It ends each cycle on the slave's acknowledge or error return, and reports the result on a one-clock response port.

A read-modify-write becomes two bus cycles with the strobe held high from the first into the second. The address stays the same. The write value is taken from the word just read: it is ANDed with one supplied mask and then ORed with another. A watchdog counts clocks while the strobe waits for an answer and ends the cycle with a timeout status when the limit is reached. Only one request is in flight at a time. The command port stays closed from acceptance until the response is issued.

Top module: `bus_cycle_master`

## Requirements
- R1: While reset is held, and on the first clock after it, bus_stb and rsp_valid are low and cmd_ready is high.
- R2: A command taken on a clock where cmd_valid and cmd_ready are both high is on the bus from the next clock. bus_stb is high, bus_addr equals cmd_addr, and bus_we is high only for cmd_op 1 (write), with bus_wdata equal to cmd_wdata. cmd_op 0 is a read, 2 is a read-modify-write and 3 acts as a read. bus_stb never rises without such an acceptance.
- R3: While bus_stb is high and neither bus_ack nor bus_err is seen, bus_addr, bus_we and bus_wdata hold and bus_stb stays high, unless the watchdog limit is reached.
- R4: A cycle ends on the clock where bus_ack is high. On the next clock bus_stb is low (except inside a read-modify-write), rsp_valid is high and rsp_status is 0 (ok). rsp_rdata is the bus_rdata sampled on the acknowledging clock of the read, and zero for a write.
- R5: A cycle answered after N wait states keeps bus_stb high for exactly N+1 clocks, including N = 0, where bus_ack arrives in the first strobe clock.
- R6: In a read-modify-write, on the clock after the read is acknowledged, bus_stb stays high with bus_we high at the same address. bus_wdata is (read word AND cmd_and_mask) OR cmd_or_mask, and no idle clock separates the two cycles.
- R7: bus_err without bus_ack ends the cycle with rsp_status 1 (bus error). If it ends the read half of a read-modify-write, no write cycle follows and rsp_rdata is zero. If it ends the write half, rsp_rdata still carries the word read.
- R8: If neither bus_ack nor bus_err comes within TIMEOUT (default 255) strobe clocks of one cycle, bus_stb drops after exactly TIMEOUT clocks and rsp_status is 2 (timeout).
- R9: cmd_ready is low from the clock after acceptance until the response is issued. cmd_valid in that window starts no cycle and changes no slave state.
- R10: rsp_valid is high for exactly one clock per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command port open (no cycle pending) |
| cmd_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write value for a plain write |
| cmd_and_mask | input | DW | Read-modify-write AND mask |
| cmd_or_mask | input | DW | Read-modify-write OR mask |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_we | output | 1 | High for a write cycle |
| bus_stb | output | 1 | Cycle qualifier |
| bus_rdata | input | DW | Read data from slave |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_rdata | output | DW | Read word (zero when none was captured) |
| rsp_status | output | 2 | 0 ok, 1 bus error, 2 timeout |

## Verification
The hardest case to reach is a read-modify-write whose read succeeds and whose write half then fails or stalls. Reaching it needs the slave to answer differently on the two halves of an unbroken strobe. The bench slave model therefore takes, per command, separate wait counts for read and write cycles and a fault mode that errors only the read half, errors only the write half, or never answers. Random commands mix these settings with zero-wait answers. Directed cases add a command offered while a slow read is still pending, followed by a read back of the address that command targeted.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

   typedef enum logic [1:0] {
      OP_READ     = 2'd0,
      OP_WRITE    = 2'd1,
      OP_RMW      = 2'd2,
      OP_READ_ALT = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_BUSERR  = 2'd1,
      ST_TIMEOUT = 2'd2,
      ST_RSVD    = 2'd3
   } status_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2
   } phase_e;

endpackage

// File: rtl/bcm_merge.sv
module bcm_merge #(
   parameter int DW   = 32,
   parameter int LANE = 8
) (
   input  logic [DW-1:0] rd_word,
   input  logic [DW-1:0] and_mask,
   input  logic [DW-1:0] or_mask,
   output logic [DW-1:0] merged
);
   localparam int NLANE = DW / LANE;

   if (LANE < 1 || (DW % LANE) != 0) begin : g_bad_lane
      $error("bcm_merge: DW must be a multiple of LANE");
   end

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign merged[g*LANE +: LANE] =
         (rd_word[g*LANE +: LANE] & and_mask[g*LANE +: LANE]) | or_mask[g*LANE +: LANE];
   end

endmodule

// File: rtl/bcm_watchdog.sv
module bcm_watchdog #(
   parameter int LIMIT = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   output logic expired
);
   localparam int TW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("bcm_watchdog: LIMIT must be at least 2");
   end

   logic [TW-1:0] cnt_q;

   assign expired = waiting && (cnt_q == TW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (waiting && !expired) cnt_q <= cnt_q + 1'b1;
      else                          cnt_q <= '0;
   end

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < TW'(LIMIT));

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !waiting |=> cnt_q == '0);

endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
   import bcm_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int TIMEOUT = 255,
   parameter int LANE    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [1:0]    cmd_op,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   input  logic [DW-1:0] cmd_and_mask,
   input  logic [DW-1:0] cmd_or_mask,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_we,
   output logic          bus_stb,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ack,
   input  logic          bus_err,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic [1:0]    rsp_status
);

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("bus_cycle_master: AW and DW must be positive");
   end
   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("bus_cycle_master: TIMEOUT must be at least 2");
   end

   phase_e        phase_q;
   op_e           op_q;
   status_e       status_q;
   logic [DW-1:0] and_q, or_q, rd_q, merged;
   logic          waiting, wd_expired, done_ok, finish;
   status_e       finish_st;

   assign cmd_ready  = (phase_q == PH_IDLE);
   assign rsp_rdata  = rd_q;
   assign rsp_status = status_q;
   assign waiting    = bus_stb && !bus_ack && !bus_err;

   bcm_merge #(.DW(DW), .LANE(LANE)) u_merge (
      .rd_word (bus_rdata),
      .and_mask(and_q),
      .or_mask (or_q),
      .merged  (merged)
   );

   bcm_watchdog #(.LIMIT(TIMEOUT)) u_wd (
      .clk    (clk),
      .rst_n  (rst_n),
      .waiting(waiting),
      .expired(wd_expired)
   );

   always_comb begin
      done_ok   = bus_stb && bus_ack;
      finish    = 1'b0;
      finish_st = ST_OK;
      if (phase_q != PH_IDLE) begin
         if (done_ok) begin
            finish = !(phase_q == PH_READ && op_q == OP_RMW);
         end else if (bus_err) begin
            finish    = 1'b1;
            finish_st = ST_BUSERR;
         end else if (wd_expired) begin
            finish    = 1'b1;
            finish_st = ST_TIMEOUT;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         op_q      <= OP_READ;
         status_q  <= ST_OK;
         and_q     <= '0;
         or_q      <= '0;
         rd_q      <= '0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         bus_we    <= 1'b0;
         bus_stb   <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (cmd_valid) begin
                  op_q     <= op_e'(cmd_op);
                  and_q    <= cmd_and_mask;
                  or_q     <= cmd_or_mask;
                  rd_q     <= '0;
                  bus_addr <= cmd_addr;
                  bus_stb  <= 1'b1;
                  if (op_e'(cmd_op) == OP_WRITE) begin
                     bus_we    <= 1'b1;
                     bus_wdata <= cmd_wdata;
                     phase_q   <= PH_WRITE;
                  end else begin
                     bus_we  <= 1'b0;
                     phase_q <= PH_READ;
                  end
               end
            end
            PH_READ: begin
               if (done_ok) begin
                  rd_q <= bus_rdata;
                  if (op_q == OP_RMW) begin
                     bus_we    <= 1'b1;
                     bus_wdata <= merged;
                     phase_q   <= PH_WRITE;
                  end
               end
            end
            PH_WRITE: begin
            end
            default: phase_q <= PH_IDLE;
         endcase
         if (finish) begin
            bus_stb   <= 1'b0;
            bus_we    <= 1'b0;
            rsp_valid <= 1'b1;
            status_q  <= finish_st;
            phase_q   <= PH_IDLE;
         end
      end
   end

   p_stb_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_stb) |-> $past(cmd_valid && cmd_ready));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && !bus_ack && !bus_err && !wd_expired) |=>
         (bus_stb && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

   p_wr_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && bus_ack && bus_we) |=>
         (!bus_stb && rsp_valid && rsp_status == ST_OK));

   p_rmw_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_READ && op_q == OP_RMW && bus_stb && bus_ack) |=>
         (bus_stb && bus_we && $stable(bus_addr)));

   p_err_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && bus_err && !bus_ack) |=>
         (!bus_stb && rsp_valid && rsp_status == ST_BUSERR));

   p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wd_expired |=> (!bus_stb && rsp_valid && rsp_status == ST_TIMEOUT));

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stb |-> !cmd_ready);

   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: tb/bus_cycle_master_test.sv
`timescale 1ns/1ps
module bus_cycle_master_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd0;
   logic [31:0] cmd_addr = '0, cmd_wdata = '0, cmd_and_mask = '0, cmd_or_mask = '0;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic        bus_we, bus_stb, bus_ack, bus_err;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [1:0]  rsp_status;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // slave model configuration: wait states per cycle type, fault mode
   // fault: 0 none, 1 error on read cycles, 2 error on write cycles, 3 never answer
   int rd_wait = 0, wr_wait = 0, fault = 0;
   int wcnt;
   logic [31:0] smem [16];
   logic [31:0] exp_mem [16];
   logic respond, is_err;

   always #2.5 clk = ~clk;

   bus_cycle_master uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_and_mask(cmd_and_mask), .cmd_or_mask(cmd_or_mask),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_stb(bus_stb),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status)
   );

   function automatic logic [31:0] init_word(int i);
      return 32'hA5000000 ^ (32'(i) * 32'h01010101);
   endfunction

   always_comb begin
      respond   = bus_stb && (wcnt == (bus_we ? wr_wait : rd_wait)) && (fault != 3);
      is_err    = respond && ((fault == 1 && !bus_we) || (fault == 2 && bus_we));
      bus_ack   = respond && !is_err;
      bus_err   = is_err;
      bus_rdata = smem[bus_addr[3:0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= 0;
         for (int i = 0; i < 16; i++) smem[i] <= init_word(i);
      end else begin
         if (!bus_stb || bus_ack || bus_err) wcnt <= 0;
         else wcnt <= wcnt + 1;
         if (bus_stb && bus_ack && bus_we) smem[bus_addr[3:0]] <= bus_wdata;
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // one command end to end, expected values from the requirements
   task automatic run_cmd(int op, int addr, logic [31:0] wd, logic [31:0] am,
                          logic [31:0] om, int rw, int ww, int fm, bit poke);
      int p; int st; logic [31:0] erd; logic [31:0] rdv; bit wr_mem; logic [31:0] nv;
      int hi; int n; string tag; bit seen_wr;
      rdv = exp_mem[addr]; wr_mem = 0; nv = '0; erd = '0;
      if (op == 1) begin
         p = (fm == 3) ? 255 : ww + 1;
         st = (fm == 3) ? 2 : (fm == 2) ? 1 : 0;
         if (fm == 0 || fm == 1) begin wr_mem = 1; nv = wd; end
         tag = (fm == 3) ? "R8" : (fm == 2) ? "R7" : "R5";
      end else if (op == 2) begin
         nv = (rdv & am) | om;
         if (fm == 3)      begin p = 255; st = 2; tag = "R8"; end
         else if (fm == 1) begin p = rw + 1; st = 1; tag = "R7"; end
         else if (fm == 2) begin p = rw + ww + 2; st = 1; erd = rdv; tag = "R7"; end
         else begin p = rw + ww + 2; st = 0; erd = rdv; wr_mem = 1; tag = "R6"; end
      end else begin
         if (fm == 3)      begin p = 255; st = 2; tag = "R8"; end
         else if (fm == 1) begin p = rw + 1; st = 1; tag = "R7"; end
         else begin p = rw + 1; st = 0; erd = rdv; tag = "R5"; end
      end

      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      rd_wait = rw; wr_wait = ww; fault = fm;
      cmd_op = 2'(op); cmd_addr = 32'(addr); cmd_wdata = wd;
      cmd_and_mask = am; cmd_or_mask = om; cmd_valid = 1'b1;
      @(negedge clk);
      if (poke) begin
         cmd_op = 2'd1; cmd_addr = 32'd7; cmd_wdata = 32'hDEADBEEF;
      end else cmd_valid = 1'b0;
      chk("R2", "strobe after accept", 32'(bus_stb), 32'd1);
      chk("R2", "address", bus_addr, 32'(addr));
      chk("R2", "write flag", 32'(bus_we), 32'(op == 1));
      if (op == 1) chk("R2", "write data", bus_wdata, wd);
      hi = 0; n = 0; seen_wr = 0;
      while (!rsp_valid && n < 400) begin
         if (bus_stb) begin
            hi++;
            chk("R9", "ready while pending", 32'(cmd_ready), 32'd0);
         end
         if (op == 2 && bus_we && !seen_wr) begin
            seen_wr = 1;
            chk("R6", "merged write data", bus_wdata, nv);
            chk("R6", "same address", bus_addr, 32'(addr));
            chk("R6", "write half after read", 32'(n), 32'(rw + 1));
         end
         n++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(tag, "strobe clocks", 32'(hi), 32'(p));
      chk(tag, "clocks to response", 32'(n), 32'(p));
      chk(st == 0 ? "R4" : tag, "status", 32'(rsp_status), 32'(st));
      chk(st == 0 ? "R4" : tag, "read data", rsp_rdata, erd);
      chk("R4", "strobe low at response", 32'(bus_stb), 32'd0);
      if (op == 2 && fm == 1) chk("R7", "no write half", 32'(seen_wr), 32'd0);
      if (wr_mem) exp_mem[addr] = nv;
      @(negedge clk);
      chk("R10", "response one clock", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) exp_mem[i] = init_word(i);
      repeat (3) @(negedge clk);
      chk("R1", "strobe in reset", 32'(bus_stb), 32'd0);
      chk("R1", "ready in reset", 32'(cmd_ready), 32'd1);
      chk("R1", "response in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "strobe after reset", 32'(bus_stb), 32'd0);
      chk("R1", "ready after reset", 32'(cmd_ready), 32'd1);

      // directed corner cases
      run_cmd(1, 3, 32'h12345678, '0, '0, 0, 0, 0, 0);        // zero-wait write
      run_cmd(0, 3, '0, '0, '0, 0, 0, 0, 0);                  // zero-wait read
      run_cmd(3, 5, '0, '0, '0, 2, 0, 0, 0);                  // code 3 as read
      run_cmd(2, 4, '0, 32'hFFFF00FF, 32'h00005A00, 0, 0, 0, 0);
      run_cmd(2, 6, '0, 32'h0F0F0F0F, 32'h80000001, 3, 2, 0, 0);
      run_cmd(0, 2, '0, '0, '0, 1, 0, 1, 0);                  // read error
      run_cmd(1, 2, 32'h0BADF00D, '0, '0, 0, 3, 2, 0);        // write error
      run_cmd(2, 8, '0, 32'h0, 32'hFFFFFFFF, 1, 0, 1, 0);     // error on read half
      run_cmd(0, 8, '0, '0, '0, 0, 0, 0, 0);
      run_cmd(2, 9, '0, 32'h0, 32'h11111111, 0, 1, 2, 0);     // error on write half
      run_cmd(0, 9, '0, '0, '0, 0, 0, 0, 0);
      run_cmd(0, 7, '0, '0, '0, 5, 0, 0, 1);                  // command offered while busy
      run_cmd(0, 7, '0, '0, '0, 0, 0, 0, 0);
      run_cmd(0, 1, '0, '0, '0, 0, 0, 3, 0);                  // read timeout
      run_cmd(1, 1, 32'h55AA55AA, '0, '0, 0, 0, 3, 0);        // write timeout
      run_cmd(0, 1, '0, '0, '0, 0, 0, 0, 0);

      // constrained random mix
      for (int k = 0; k < 250; k++) begin
         int r; int f;
         r = int'($urandom % 10);
         f = (r < 8) ? 0 : (r == 8) ? 1 : 2;
         run_cmd(int'($urandom % 4), int'($urandom % 16), $urandom, $urandom, $urandom,
                 int'($urandom % 4), int'($urandom % 4), f, ($urandom % 8) == 0);
      end
      for (int i = 0; i < 16; i++) run_cmd(0, i, '0, '0, '0, 0, 0, 0, 0);
      summary();
   end

endmodule